// File: doc/BRIEF.md
# Signal-Strength Sample Sequencer

This block decides when a received-signal-strength reading is taken and holds the reading for software. While the receiver is enabled it watches a carrier-present level. The level is either the front end's carrier detect or a software force bit. Once that level has held steadily for longer than a qualification window, the block sends one start pulse to an external 5-bit converter. It waits for the converter's done pulse and stores the code together with a valid flag in an 8-bit status word.

After that single reading the block parks. No carrier activity and no stray converter pulse will change the stored reading. Software takes a fresh reading by turning receive mode off and on again. Turning receive off also empties the status word. The force bit lets software measure a quiet channel's noise floor when no carrier is present.

Top module: `rssi_sequencer`

## Requirements
- R1: During and directly after a synchronous active-low reset, `rssi_status` is 8'h00 and `adc_start` is 0.
- R2: With `rx_en` high, the qualification window begins on the clock edge that first samples `rx_en` high. From the next edge onward, effective carrier (`carrier_det` OR `force_cd`) is counted. `adc_start` goes high in the cycle after the edge that samples the (QUAL_CYCLES+1)-th consecutive high effective carrier, where QUAL_CYCLES = CLK_MHZ*QUAL_US. It never goes high earlier.
- R3: A sampled low effective carrier during qualification restarts the consecutive count from zero.
- R4: `force_cd` high qualifies exactly like `carrier_det` high, so a reading is taken with `carrier_det` held low.
- R5: `adc_start` is high for exactly one cycle, and at most once per receive session (one `rx_en` high period).
- R6: An `adc_done` pulse sampled while the block waits after its start pulse makes `rssi_status[4:0]` equal to the `adc_code` sampled on that edge and `rssi_status[5]` equal to 1 from the next cycle.
- R7: Once the valid bit (bit 5) is set and `rx_en` stays high, `rssi_status` does not change, whatever `carrier_det`, `force_cd`, `adc_done` or `adc_code` do. An `adc_done` pulse outside the wait leaves the status unchanged.
- R8: An edge that samples `rx_en` low makes `rssi_status` 8'h00 from the next cycle and returns the block to idle. Raising `rx_en` again re-arms R2.
- R9: `rssi_status[7:6]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive mode enable; a low level ends the session |
| carrier_det | input | 1 | On-channel carrier present level |
| force_cd | input | 1 | Software force of carrier present |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | One-cycle conversion done pulse |
| adc_code | input | CODE_W (5) | Converter result, valid with `adc_done` |
| rssi_status | output | 8 | {2'b00, valid, code[4:0]} |

## Verification
The bench hits the carrier edge one sample short of qualification and then exactly on it. A counter that is off by one there would start a cycle early or late. It drops the carrier mid-window, so a design that pauses instead of restarting the count would start too soon. It fires stray done pulses before the start pulse and during the halt, and a design that latched them would show a wrong code or a premature valid bit. It also cycles receive enable at random points, including during the converter wait. A design that left stale results behind, or failed to re-arm for the next session, would be caught there.

// File: rtl/rssi_seq_pkg.sv
// Shared types for the signal-strength sample sequencer.
// Assumes nothing beyond IEEE 1800-2017 package support.
package rssi_seq_pkg;

    // Sequencer phases of one receive session
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_QUAL  = 3'd1,
        SEQ_START = 3'd2,
        SEQ_WAIT  = 3'd3,
        SEQ_HALT  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/rssi_persist_cnt.sv
// Carrier persistence counter.
// Counts consecutive cycles of a high level while not cleared, and saturates at TERM.
// qual_met is high when the level is high on a cycle where the count already sits at TERM.
// That cycle is the (TERM+1)-th consecutive high sample.
// Assumes TERM >= 1.
module rssi_persist_cnt #(
    parameter int TERM = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic level,
    output logic qual_met
);
    localparam int CNT_W = $clog2(TERM + 1);
    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

    logic [CNT_W-1:0] cnt_q;

    // Terminal detect for the qualification window
    always_comb begin
        qual_met = level && (cnt_q == TERM_V);
    end

    // Consecutive-sample counter with restart on a low sample or on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !level) begin
            cnt_q <= '0;
        end else if (cnt_q != TERM_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM_V);

    // R3
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !level |=> !qual_met);

endmodule

// File: rtl/rssi_seq_fsm.sv
// Session state machine.
// Sequence: idle, qualify the carrier, issue one start pulse, wait for done, then halt.
// Low rx_en sends any state back to idle.
// Assumes qual_met comes from a counter that is cleared outside the qualify phase.
module rssi_seq_fsm
    import rssi_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       qual_met,
    input  logic       adc_done,
    output seq_state_t state,
    output logic       adc_start,
    output logic       capture,
    output logic       cnt_clear
);
    seq_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state;
        if (!rx_en) begin
            state_d = SEQ_IDLE;
        end else begin
            case (state)
                SEQ_IDLE:  state_d = SEQ_QUAL;
                SEQ_QUAL:  if (qual_met) state_d = SEQ_START;
                SEQ_START: state_d = SEQ_WAIT;
                SEQ_WAIT:  if (adc_done) state_d = SEQ_HALT;
                SEQ_HALT:  state_d = SEQ_HALT;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_d;
    end

    // Phase-decoded outputs
    always_comb begin
        adc_start = (state == SEQ_START);
        capture   = (state == SEQ_WAIT) && adc_done && rx_en;
        cnt_clear = (state != SEQ_QUAL);
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R2
    start_after_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> $past(qual_met));

    // R6
    capture_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == SEQ_HALT));

    // R8
    rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == SEQ_IDLE));

endmodule

// File: rtl/rssi_result_reg.sv
// Result holding register.
// Loads the converter code and sets valid on capture, and holds the value afterwards.
// Empties whenever rx_en is sampled low.
// Assumes capture fires at most once per session.
module rssi_result_reg #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              valid_q
);
    // Capture, hold and clear of the stored reading
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else if (capture) begin
            code_q  <= code_in;
            valid_q <= 1'b1;
        end
    end

    // R7
    hold_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && rx_en) |=> ($stable(code_q) && valid_q));

    // R8
    clear_on_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (code_q == '0 && !valid_q));

    // R6
    valid_from_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(capture));

endmodule

// File: rtl/rssi_sequencer.sv
// Top of the signal-strength sample sequencer.
// Combines the carrier and force inputs into one carrier level and qualifies it for
// CLK_MHZ*QUAL_US cycles. It then takes one reading per session and presents
// {zeros, valid, code} as a status word.
// Assumes adc_done and adc_code come from a converter that pulses done once per start.
module rssi_sequencer
    import rssi_seq_pkg::*;
#(
    parameter int CLK_MHZ  = 1,
    parameter int QUAL_US  = 50,
    parameter int CODE_W   = 5,
    parameter int STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                carrier_det,
    input  logic                force_cd,
    output logic                adc_start,
    input  logic                adc_done,
    input  logic [CODE_W-1:0]   adc_code,
    output logic [STATUS_W-1:0] rssi_status
);
    localparam int QUAL_CYCLES = CLK_MHZ * QUAL_US;
    localparam int PAD_W       = STATUS_W - CODE_W - 1;

    seq_state_t        state;
    logic              cd_eff;
    logic              qual_met;
    logic              capture;
    logic              cnt_clear;
    logic [CODE_W-1:0] code_q;
    logic              valid_q;

    // Effective carrier: detected or forced by software
    always_comb begin
        cd_eff = carrier_det | force_cd;
    end

    rssi_persist_cnt #(
        .TERM (QUAL_CYCLES)
    ) u_persist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .level    (cd_eff),
        .qual_met (qual_met)
    );

    rssi_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .qual_met  (qual_met),
        .adc_done  (adc_done),
        .state     (state),
        .adc_start (adc_start),
        .capture   (capture),
        .cnt_clear (cnt_clear)
    );

    rssi_result_reg #(
        .CODE_W (CODE_W)
    ) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (rx_en),
        .capture (capture),
        .code_in (adc_code),
        .code_q  (code_q),
        .valid_q (valid_q)
    );

    // Status word assembly with zero upper bits
    always_comb begin
        rssi_status = {{PAD_W{1'b0}}, valid_q, code_q};
    end

    // R4
    force_qualifies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> $past(cd_eff));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!adc_start && rssi_status == '0));

endmodule

// File: tb/rssi_sequencer_bench.sv
module rssi_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int QUAL_US    = 8;
    localparam int Q          = CLK_MHZ * QUAL_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       carrier_det = 1'b0;
    logic       force_cd = 1'b0;
    logic       adc_start;
    logic       adc_done = 1'b0;
    logic [4:0] adc_code = 5'd0;
    logic [7:0] rssi_status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    int       m_st = 0;   // 0 idle,1 qual,2 start,3 wait,4 halt
    int       m_run = 0;
    logic [4:0] m_res = 5'd0;
    logic     m_val = 1'b0;

    // converter responder
    int       pend = 0;
    bit       use_fixed = 1'b0;
    logic [4:0] fixed_code = 5'd0;
    bit       stray_en = 1'b1;
    int       starts = 0;
    int       seed_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_sequencer #(.CLK_MHZ(CLK_MHZ), .QUAL_US(QUAL_US)) u_rssi_sequencer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .carrier_det(carrier_det),
        .force_cd(force_cd), .adc_start(adc_start), .adc_done(adc_done),
        .adc_code(adc_code), .rssi_status(rssi_status)
    );

    function automatic logic [7:0] exp_status(logic v, logic [4:0] c);
        return {2'b00, v, c};
    endfunction

    // Model from the requirements, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_res = 0; m_val = 0;
        end else if (!rx_en) begin
            m_st = 0; m_run = 0; m_res = 0; m_val = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_run = 0; end
                1: begin
                    if (carrier_det || force_cd) begin
                        if (m_run == Q) m_st = 2;
                        else m_run = m_run + 1;
                    end else m_run = 0;
                end
                2: m_st = 3;
                3: if (adc_done) begin m_res = adc_code; m_val = 1; m_st = 4; end
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs
    task automatic step(input logic rx, input logic cd, input logic fc);
        @(negedge clk);
        chk("R2 adc_start", int'(adc_start), (rst_n && m_st == 2) ? 1 : 0);
        chk("R6 code", int'(rssi_status[4:0]), int'(m_res));
        chk("R6 valid", int'(rssi_status[5]), int'(m_val));
        chk("R9 upper bits", int'(rssi_status[7:6]), 0);
        if (adc_start) begin
            starts++;
            pend = 1 + int'($urandom % 4);
        end
        adc_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                adc_done = 1'b1;
                adc_code = use_fixed ? fixed_code : 5'($urandom);
            end
        end else if (stray_en && ($urandom % 8 == 0)) begin
            adc_done = 1'b1;
            adc_code = 5'($urandom);
        end
        rx_en = rx; carrier_det = cd; force_cd = fc;
    endtask

    initial begin
        seed_v = $urandom(32'h5eed_0042);
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [7:0] held;
        // R1: reset state
        repeat (3) step(0, 0, 0);
        chk("R1 status in reset", int'(rssi_status), 0);
        chk("R1 start in reset", int'(adc_start), 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0);
        chk("R1 status after reset", int'(rssi_status), 0);

        // R2: exact latency with steady carrier, fixed code for R6
        stray_en = 1'b0; use_fixed = 1'b1; fixed_code = 5'h13;
        starts = 0;
        step(1, 1, 0);
        lat = 0;
        for (int i = 1; i <= Q + 10; i++) begin
            step(1, 1, 0);
            if (adc_start && lat == 0) lat = i;
        end
        chk("R2 start latency", lat, Q + 2);
        chk("R6 captured status", int'(rssi_status), int'(exp_status(1'b1, 5'h13)));

        // R7: halt holds despite activity and stray done pulses
        stray_en = 1'b1; use_fixed = 1'b0;
        held = rssi_status;
        for (int i = 0; i < 30; i++) step(1, 1'($urandom), 1'($urandom));
        chk("R7 status held in halt", int'(rssi_status), int'(held));
        chk("R5 one start per session", starts, 1);

        // R8: receive off clears
        step(0, 1, 0);
        step(0, 0, 0);
        chk("R8 status cleared", int'(rssi_status), 0);

        // R3: carrier drops one sample short, then full window
        stray_en = 1'b0; starts = 0;
        step(1, 1, 0);
        for (int i = 0; i < Q; i++) step(1, 1, 0);
        step(1, 0, 0);
        for (int i = 0; i < Q; i++) step(1, 1, 0);
        step(1, 1, 0);
        chk("R3 no start before restart completes", starts, 0);
        for (int i = 0; i < 4; i++) step(1, 1, 0);
        chk("R3 start after full window", starts, 1);
        for (int i = 0; i < 8; i++) step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);

        // R4: force bit with quiet carrier
        starts = 0; use_fixed = 1'b1; fixed_code = 5'h03;
        for (int i = 0; i < Q + 10; i++) step(1, 0, 1);
        chk("R4 forced start", starts, 1);
        chk("R4 forced reading", int'(rssi_status), int'(exp_status(1'b1, 5'h03)));
        step(0, 0, 0);

        // R4 negative: quiet carrier and no force never starts
        starts = 0;
        for (int i = 0; i < 3 * Q; i++) step(1, 0, 0);
        chk("R4 quiet channel no start", starts, 0);
        step(0, 0, 0);

        // Random sessions with stray done pulses and random receive drops
        stray_en = 1'b1; use_fixed = 1'b0;
        for (int s = 0; s < 300; s++) begin
            int len = 4 + int'($urandom % 40);
            int dens = int'($urandom % 4);
            starts = 0;
            for (int i = 0; i < len; i++)
                step(1, ($urandom % 4) >= dens, ($urandom % 16) == 0);
            chk("R5 at most one start", int'(starts <= 1), 1);
            step(0, 1'($urandom), 1'($urandom));
            pend = 0;
        end
        step(0, 0, 0);
        step(0, 0, 0);
        chk("R8 final clear", int'(rssi_status), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule